// File: doc/BRIEF.md
# Asynchronous Memory Read Sequencer

This block sits between a host read port and an external asynchronous memory. It turns each host read request into a memory bus access. Each access drives the address, pulls chip select and the read strobe low for a programmed number of cycles, and captures the read data when the strobe ends. Three static inputs set the timing and the mode: a wait-state count, an acknowledge-enable flag that lets the memory stretch the strobe, and a prediction-disable flag.

With prediction enabled (the default, flag at 0), the sequencer does not sit idle after it serves a request. It starts a read at the next word address before the host asks for it and keeps the result in a one-entry buffer. If the next request names that address, the data is returned one cycle after the request is accepted. If it names another address, the buffered word is thrown away and a normal read is made. When the host marks a request as the last of a burst, the trailing access repeats that same address and returns nothing. No access of any kind ever drives the write strobe.

Top module: `amem_read_seq`

## Requirements
- R1: While rst_ni is low, and on leaving reset, mem_cs_no, mem_rd_no and mem_wr_no are high, rsp_valid_o is low and req_ready_o is high.
- R2: With ack_en_i = 0, every read strobe (mem_rd_no low) lasts exactly ws_cnt_i + 2 cycles, whatever the level of mem_ack_i.
- R3: With ack_en_i = 1, a strobe never ends before ws_cnt_i + 2 cycles. mem_ack_i is looked at only in strobe cycle ws_cnt_i + 1 (counting from 0) and later, and the strobe ends after the first such cycle in which it is high.
- R4: mem_cs_no is low exactly when mem_rd_no is low, and mem_addr_o does not change while the strobe is low.
- R5: Each accepted request produces exactly one single-cycle rsp_valid_o pulse, with rsp_data_o equal to the memory word at the requested address, captured in the last strobe cycle.
- R6: With pred_dis_i = 1, a bus access is made only for an outstanding host request. From an idle bus the response arrives ws_cnt_i + 3 cycles after the accepting clock edge.
- R7: With pred_dis_i = 0, after a request at address A with req_last_i = 0 is served, a speculative access to A + 1 follows. A later request for A + 1 that arrives after that access has finished is answered one cycle after acceptance, with no new access.
- R8: With pred_dis_i = 0, if the next request does not match the speculative address, the speculative word is dropped without a response and a full read of the requested address is made (ws_cnt_i + 3 cycle latency from an idle bus).
- R9: With pred_dis_i = 0, after a request with req_last_i = 1 is served, exactly one further access is made to the same address. It gives no response, and the bus then stays idle.
- R10: mem_wr_no is never driven low, including during speculative and repeated accesses.
- R11: A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. req_ready_o is low from acceptance until the cycle in which its response is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ws_cnt_i | input | WSW | Programmed wait states added to the two-cycle minimum strobe |
| ack_en_i | input | 1 | 1: memory acknowledge may stretch the strobe |
| pred_dis_i | input | 1 | 1: speculative reads off |
| req_valid_i | input | 1 | Host read request |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_addr_i | input | AW | Requested word address |
| req_last_i | input | 1 | Request is the last of a burst |
| rsp_valid_o | output | 1 | Response data valid pulse |
| rsp_data_o | output | DW | Response data |
| mem_addr_o | output | AW | Memory address |
| mem_cs_no | output | 1 | Memory chip select, active low |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low, held inactive |
| mem_data_i | input | DW | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
Single reads with prediction off are run at zero and non-zero wait states to pin the base strobe length and latency. The acknowledge line is held high with acknowledge disabled, and then held high from the start or raised late with it enabled. This separates an acknowledge that is ignored, one sampled too early, and one that stretches the strobe. Sequential bursts with prediction on show buffer hits by their one-cycle latency and the repeated trailing address in the access log. A jump to an unrelated address shows the dropped speculation and the full-latency re-read. A request issued in the very cycle of the previous response, and a sequential burst with prediction off, show that data stays correct when no speculation is used.

// File: rtl/amem_pkg.sv
package amem_pkg;
  typedef enum logic [1:0] {ACC_DEMAND, ACC_SPEC, ACC_DUP} acc_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_REC} bus_state_e;
endpackage

// File: rtl/amem_strobe_timer.sv
module amem_strobe_timer #(
  parameter int WSW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [WSW-1:0] ws_i,
  input  logic           ack_en_i,
  input  logic           ack_i,
  output logic           done_o
);
  localparam int CW = WSW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] min_last;
  logic          min_hit;

  assign min_last = {1'b0, ws_i} + CW'(1);
  assign min_hit  = (cnt_q >= min_last);
  assign done_o   = run_i && min_hit && (!ack_en_i || ack_i);

  // saturates once the minimum window is reached; ack wait may be unbounded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || done_o) begin
      cnt_q <= '0;
    end else if (!min_hit) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/amem_predict_buf.sv
module amem_predict_buf #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          clear_i,
  input  logic [AW-1:0] query_addr_i,
  output logic          hit_o,
  output logic [DW-1:0] data_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign hit_o  = valid_q && (addr_q == query_addr_i);
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= load_addr_i;
      data_q  <= load_data_i;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/amem_next_queue.sv
module amem_next_queue
  import amem_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pred_dis_i,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          set_last_i,
  input  logic          take_i,
  input  logic          clear_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output acc_kind_e     kind_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      kind_o  <= ACC_SPEC;
    end else if (set_i && !pred_dis_i) begin
      valid_o <= 1'b1;
      addr_o  <= set_last_i ? set_addr_i : set_addr_i + AW'(1);
      kind_o  <= set_last_i ? ACC_DUP : ACC_SPEC;
    end else if (take_i || clear_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/amem_read_seq.sv
module amem_read_seq
  import amem_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int WSW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [WSW-1:0] ws_cnt_i,
  input  logic           ack_en_i,
  input  logic           pred_dis_i,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [AW-1:0]  req_addr_i,
  input  logic           req_last_i,
  output logic           rsp_valid_o,
  output logic [DW-1:0]  rsp_data_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_cs_no,
  output logic           mem_rd_no,
  output logic           mem_wr_no,
  input  logic [DW-1:0]  mem_data_i,
  input  logic           mem_ack_i
);
  bus_state_e    state_q;
  acc_kind_e     cur_kind_q;
  logic [AW-1:0] cur_addr_q;
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  logic          pend_last_q;

  logic          t_done;
  logic          finish;
  logic          demand_done;
  logic          buf_hit;
  logic [DW-1:0] buf_data;
  logic          nq_valid;
  logic [AW-1:0] nq_addr;
  acc_kind_e     nq_kind;

  logic          launch;
  logic [AW-1:0] launch_addr;
  acc_kind_e     launch_kind;
  logic          serve_hit;
  logic          nq_take;
  logic          drop_spec;
  logic          accept;

  assign accept      = req_valid_i && req_ready_o;
  assign req_ready_o = !pend_q;
  assign finish      = (state_q == ST_BUS) && t_done;
  assign demand_done = finish && (cur_kind_q == ACC_DEMAND);

  always_comb begin
    launch      = 1'b0;
    launch_addr = pend_addr_q;
    launch_kind = ACC_DEMAND;
    serve_hit   = 1'b0;
    nq_take     = 1'b0;
    drop_spec   = 1'b0;
    if (state_q == ST_IDLE) begin
      if (pend_q) begin
        if (buf_hit) begin
          serve_hit = 1'b1;
        end else begin
          launch    = 1'b1;
          drop_spec = 1'b1;
        end
      end else if (nq_valid) begin
        launch      = 1'b1;
        launch_addr = nq_addr;
        launch_kind = nq_kind;
        nq_take     = 1'b1;
      end
    end
  end

  amem_strobe_timer #(.WSW(WSW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_BUS),
    .ws_i    (ws_cnt_i),
    .ack_en_i(ack_en_i),
    .ack_i   (mem_ack_i),
    .done_o  (t_done)
  );

  amem_predict_buf #(.AW(AW), .DW(DW)) u_pbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (finish && (cur_kind_q == ACC_SPEC)),
    .load_addr_i (cur_addr_q),
    .load_data_i (mem_data_i),
    .clear_i     (serve_hit || drop_spec),
    .query_addr_i(pend_addr_q),
    .hit_o       (buf_hit),
    .data_o      (buf_data)
  );

  amem_next_queue #(.AW(AW)) u_nq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pred_dis_i(pred_dis_i),
    .set_i     (serve_hit || demand_done),
    .set_addr_i(serve_hit ? pend_addr_q : cur_addr_q),
    .set_last_i(pend_last_q),
    .take_i    (nq_take),
    .clear_i   (drop_spec),
    .valid_o   (nq_valid),
    .addr_o    (nq_addr),
    .kind_o    (nq_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_kind_q <= ACC_DEMAND;
      cur_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q    <= ST_BUS;
          cur_addr_q <= launch_addr;
          cur_kind_q <= launch_kind;
        end
        ST_BUS:  if (t_done) state_q <= ST_REC;
        ST_REC:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_last_q <= 1'b0;
    end else if (accept) begin
      pend_q      <= 1'b1;
      pend_addr_q <= req_addr_i;
      pend_last_q <= req_last_i;
    end else if (serve_hit || demand_done) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= serve_hit || demand_done;
      if (serve_hit)        rsp_data_o <= buf_data;
      else if (demand_done) rsp_data_o <= mem_data_i;
    end
  end

  assign mem_addr_o = cur_addr_q;
  assign mem_cs_no  = (state_q != ST_BUS);
  assign mem_rd_no  = (state_q != ST_BUS);
  assign mem_wr_no  = 1'b1;
endmodule

// File: rtl/amem_read_seq_chk.sv
module amem_read_seq_chk #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int WSW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [WSW-1:0] ws_cnt_i,
  input logic           ack_en_i,
  input logic           pred_dis_i,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic           rsp_valid_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_cs_no,
  input logic           mem_rd_no,
  input logic           mem_wr_no,
  input logic [DW-1:0]  mem_data_i
);
  logic [15:0] low_len;
  logic [1:0]  outst;
  logic        acc;

  assign acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_len <= '0;
      outst   <= '0;
    end else begin
      if (!mem_rd_no) low_len <= (low_len == 16'hffff) ? low_len : low_len + 16'd1;
      else            low_len <= '0;
      outst <= outst + {1'b0, acc} - {1'b0, rsp_valid_o};
    end
  end

  // R10
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_wr_no);
  // R4
  cs_rd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_cs_no == mem_rd_no);
  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rd_no && $past(!mem_rd_no)) |-> $stable(mem_addr_o));
  // R2
  fixed_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_rd_no) && !ack_en_i) |-> (32'(low_len) == 32'(ws_cnt_i) + 2));
  // R3
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_no) |-> (32'(low_len) >= 32'(ws_cnt_i) + 2));
  // R11
  one_outst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) outst <= 2'd1);
  // R11
  ready_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outst == 2'd1 && !rsp_valid_o) |-> !req_ready_o);
  // R5
  rsp_owed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> outst == 2'd1);
  // R6
  np_demand_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_dis_i && $fell(mem_rd_no)) |-> outst == 2'd1);

  logic unused_ok;
  assign unused_ok = ^mem_data_i;
endmodule

bind amem_read_seq amem_read_seq_chk #(.AW(AW), .DW(DW), .WSW(WSW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ws_cnt_i   (ws_cnt_i),
  .ack_en_i   (ack_en_i),
  .pred_dis_i (pred_dis_i),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_addr_o (mem_addr_o),
  .mem_cs_no  (mem_cs_no),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .mem_data_i (mem_data_i)
);

// File: tb/amem_read_seq_bench.sv
`timescale 1ns/1ps
module amem_read_seq_bench;
  localparam int AW = 16, DW = 32, WSW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WSW-1:0] ws = '0;
  logic ack_en = 1'b0, pred_dis = 1'b1;
  logic req_valid = 1'b0, req_last = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_rd_n, mem_wr_n, mem_ack;
  logic [DW-1:0] rsp_data, mem_data;
  logic [AW-1:0] mem_addr;

  int errors = 0, checks = 0;
  int scnt = 0, last_len = 0, log_n = 0, rsp_n = 0;
  bit ack_on = 0;
  int ack_dly = 0;
  bit wr_bad = 0, cs_bad = 0, addr_bad = 0;
  bit ready_after = 0;
  logic [AW-1:0] log_a [0:31];
  logic [AW-1:0] prev_addr = '0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  assign mem_data = word_at(mem_addr);
  assign mem_ack  = ack_on && (scnt > ack_dly);

  amem_read_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_amem_read_seq (
    .clk_i(clk), .rst_ni(rst_n), .ws_cnt_i(ws), .ack_en_i(ack_en), .pred_dis_i(pred_dis),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_last_i(req_last), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_addr_o(mem_addr), .mem_cs_no(mem_cs_n), .mem_rd_no(mem_rd_n),
    .mem_wr_no(mem_wr_n), .mem_data_i(mem_data), .mem_ack_i(mem_ack)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_n !== 1'b1) wr_bad = 1;
      if (mem_cs_n !== mem_rd_n) cs_bad = 1;
      if (!mem_rd_n) begin
        if (scnt == 0) begin
          if (log_n < 32) log_a[log_n] = mem_addr;
          log_n++;
        end else if (mem_addr != prev_addr) addr_bad = 1;
        scnt++;
      end else if (scnt != 0) begin
        last_len = scnt;
        scnt = 0;
      end
      prev_addr = mem_addr;
      if (rsp_valid) rsp_n++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    log_n = 0; rsp_n = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit last, output logic [DW-1:0] d, output int lat);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_last = last;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    ready_after = req_ready;
    lat = 0;
    while (!rsp_valid && lat < 1000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    d = rsp_data;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "cs_n in reset", mem_cs_n, 1);
    chk("R1", "rd_n in reset", mem_rd_n, 1);
    chk("R1", "wr_n in reset", mem_wr_n, 1);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "rd_n after reset", mem_rd_n, 1);
  endtask

  task automatic t_single_np();
    logic [DW-1:0] d; int lat;
    ws = 3; ack_en = 0; pred_dis = 1; ack_on = 0; clear_mon();
    do_read(16'h0005, 1, d, lat);
    chk("R5", "np data", d, word_at(16'h0005));
    chk("R6", "np latency", lat, 6);
    chk("R11", "ready low while outstanding", ready_after, 0);
    repeat (20) @(negedge clk);
    chk("R2", "strobe len ws3", last_len, 5);
    chk("R6", "np access count", log_n, 1);
    chk("R5", "np response count", rsp_n, 1);
  endtask

  task automatic t_ws_zero();
    logic [DW-1:0] d; int lat;
    ws = 0; clear_mon();
    do_read(16'h0100, 1, d, lat);
    repeat (5) @(negedge clk);
    chk("R2", "strobe len ws0", last_len, 2);
    chk("R5", "ws0 data", d, word_at(16'h0100));
  endtask

  task automatic t_ack_ignored();
    logic [DW-1:0] d; int lat;
    ws = 2; ack_en = 0; ack_on = 1; ack_dly = 0; clear_mon();
    do_read(16'h0200, 1, d, lat);
    repeat (5) @(negedge clk);
    chk("R2", "ack ignored when disabled", last_len, 4);
    ack_on = 0;
    do_read(16'h0201, 1, d, lat);
    repeat (5) @(negedge clk);
    chk("R2", "ack low when disabled", last_len, 4);
  endtask

  task automatic t_ack_wait();
    logic [DW-1:0] d; int lat;
    ws = 2; ack_en = 1; ack_on = 1; ack_dly = 7; clear_mon();
    do_read(16'h0300, 1, d, lat);
    repeat (5) @(negedge clk);
    chk("R3", "strobe stretched by ack", last_len, 8);
    chk("R3", "stretched data", d, word_at(16'h0300));
    ack_dly = 0;
    do_read(16'h0301, 1, d, lat);
    repeat (5) @(negedge clk);
    chk("R3", "early ack not honoured", last_len, 4);
    ack_en = 0; ack_on = 0;
  endtask

  task automatic t_pred_seq();
    logic [DW-1:0] d; int lat;
    ws = 1; pred_dis = 0; clear_mon();
    do_read(16'h0010, 0, d, lat);
    chk("R7", "first burst read latency", lat, 4);
    chk("R5", "data 0x10", d, word_at(16'h0010));
    repeat (12) @(negedge clk);
    do_read(16'h0011, 0, d, lat);
    chk("R7", "predicted hit latency", lat, 1);
    chk("R7", "predicted data 0x11", d, word_at(16'h0011));
    repeat (12) @(negedge clk);
    do_read(16'h0012, 1, d, lat);
    chk("R7", "predicted hit latency last", lat, 1);
    chk("R7", "predicted data 0x12", d, word_at(16'h0012));
    repeat (15) @(negedge clk);
    chk("R9", "access count with repeat", log_n, 4);
    chk("R7", "spec addr 1", log_a[1], 16'h0011);
    chk("R9", "repeat addr", log_a[3], 16'h0012);
    chk("R9", "no response for repeat", rsp_n, 3);
  endtask

  task automatic t_pred_miss();
    logic [DW-1:0] d; int lat;
    ws = 1; pred_dis = 0; clear_mon();
    do_read(16'h0020, 0, d, lat);
    repeat (12) @(negedge clk);
    do_read(16'h0040, 1, d, lat);
    chk("R8", "miss latency", lat, 4);
    chk("R8", "miss data", d, word_at(16'h0040));
    repeat (15) @(negedge clk);
    chk("R8", "dropped spec addr", log_a[1], 16'h0021);
    chk("R8", "demand after miss", log_a[2], 16'h0040);
    chk("R8", "responses after miss", rsp_n, 2);
    chk("R9", "repeat after miss", log_a[3], 16'h0040);
  endtask

  task automatic t_back_to_back();
    logic [DW-1:0] d; int lat;
    ws = 2; pred_dis = 0; clear_mon();
    do_read(16'h0060, 0, d, lat);
    chk("R5", "b2b data 0x60", d, word_at(16'h0060));
    do_read(16'h0061, 1, d, lat);
    chk("R5", "b2b data 0x61", d, word_at(16'h0061));
    repeat (15) @(negedge clk);
    chk("R5", "b2b response count", rsp_n, 2);
  endtask

  task automatic t_np_seq();
    logic [DW-1:0] d; int lat;
    ws = 1; pred_dis = 1; clear_mon();
    do_read(16'h0050, 0, d, lat);
    repeat (12) @(negedge clk);
    do_read(16'h0051, 1, d, lat);
    chk("R6", "np sequential latency", lat, 4);
    chk("R6", "np sequential data", d, word_at(16'h0051));
    repeat (15) @(negedge clk);
    chk("R6", "np sequential accesses", log_n, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single_np();
    t_ws_zero();
    t_ack_ignored();
    t_ack_wait();
    t_pred_seq();
    t_pred_miss();
    t_back_to_back();
    t_np_seq();
    chk("R10", "write strobe seen", wr_bad, 0);
    chk("R4", "cs/rd mismatch seen", cs_bad, 0);
    chk("R4", "addr moved in strobe", addr_bad, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R5 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule